// File: doc/BRIEF.md
# Halt and Priority Interrupt Controller

This block sits beside a small CPU core. It tracks whether the core is halted and resolves which interrupt request the core should service next. Four active-low external request lines come in, each with its own priority. A fifth source, level 0, outranks all of them. Level 0 is raised through a single halt line when the continue input is sequenced against it.

The halt line is bidirectional, and the block drives it through separate value and enable outputs. Executing a halt instruction drives the line high to announce the halt. A falling edge forced onto the line from outside also halts the core, but in that case the block leaves the line undriven. A rising edge on the continue input ends the halt. If that rising edge arrives while the halt line is held low, it also raises a level-0 request.

The core reads a level code and a valid flag. The pair stays fixed until the core accepts it with its take input. The block then answers with a one-clock acknowledge, which is meant to drive the continue line outward. That acknowledge also releases any halt.

Top module: `halt_irq_ctrl`

## Requirements
- R1: While `rst_n` is low and just after it rises, `irq_valid_o`, `cont_ack_o`, `halted_o` and `halt_line_oe_o` are all 0.
- R2: Bit k of `irq_n_i` (k = 0..3) is serviced as level code k+2. If it is held low with enable bit `irq_en_i[k+1]` set and no request is held, `irq_valid_o` rises on the third rising edge after the change and not on the second.
- R3: When several enabled requests are pending together, the lowest level code wins. Level 0 beats every external line, and `irq_n_i[0]` beats the other external lines.
- R4: An external line whose enable bit is 0 never produces `irq_valid_o`.
- R5: Once `irq_valid_o` is 1, it and `irq_level_o` stay unchanged until `take_i` is sampled high. This holds even if a higher-priority request appears or the original line is released.
- R6: `take_i` sampled high while `irq_valid_o` is 1 gives `cont_ack_o` = 1 for exactly one clock, starting at that edge, and `irq_valid_o` falls at the same edge.
- R7: `halt_instr_i` sampled high sets `halted_o` at that edge and drives the halt line high (`halt_line_oe_o` = 1, `halt_line_o` = 1). The line is driven only while `halted_o` is 1.
- R8: A falling edge on the received halt line sets `halted_o` on the third rising edge after the change, with `halt_line_oe_o` left at 0.
- R9: A rising edge on `cont_i` clears `halted_o` on the third rising edge after the change, and not on the second.
- R10: A rising edge on `cont_i` while the received halt line is low, with `irq_en_i[0]` = 1, leaves a level-0 request pending. That request is reported as `irq_level_o` = 0 one edge after the halt clears, and the acknowledge of level 0 removes it.
- R11: The acknowledge clears `halted_o` and the halt line drive.
- R12: With `irq_en_i[0]` = 0, the continue-while-halt-low sequence raises no request but still ends the halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low init; clears halt and interrupt state |
| irq_n_i | input | 4 | Active-low external requests, bit 0 highest priority |
| irq_en_i | input | 5 | Enables: bit 0 level 0, bit k+1 for `irq_n_i[k]` |
| halt_instr_i | input | 1 | Core executes a halt instruction (one-clock pulse) |
| halt_line_i | input | 1 | Value received from the bidirectional halt line |
| halt_line_o | output | 1 | Value driven onto the halt line |
| halt_line_oe_o | output | 1 | Drive enable for the halt line |
| cont_i | input | 1 | Continue input |
| cont_ack_o | output | 1 | One-clock acknowledge, driven onto the continue line |
| take_i | input | 1 | Core accepts the presented request |
| irq_valid_o | output | 1 | A request is presented |
| irq_level_o | output | 3 | Level code of the presented request (0, 2..5) |
| halted_o | output | 1 | Core is in the halt state |

## Verification
The assertions check four rules on every cycle: the acknowledge lasts exactly one clock and removes the presented request, a held request keeps its code until taken, the halt line is driven only while halted, and the reported code never takes an illegal value. Some behaviours can only be shown by the bench's scenarios. These are the latency through the input synchronisers, the winner of a priority contest, the effect of masking, and the ordering test that tells a level-0 sequence apart from a plain continue.

// File: rtl/hic_pkg.sv
package hic_pkg;
    localparam int N_EXT  = 4;                 // external request lines
    localparam int N_REQ  = N_EXT + 1;         // plus level 0
    localparam int IDX_W  = $clog2(N_REQ);
    localparam int LVL_W  = $clog2(N_EXT + 2); // codes 0 and 2..N_EXT+1

    typedef struct packed {
        logic             valid;
        logic [LVL_W-1:0] level;
        logic             ack;
        logic             halted;
        logic             drive;
        logic             lvl0_pend;
        logic             halt_prev;
        logic             cont_prev;
    } hic_state_t;
endpackage

// File: rtl/hic_sync.sv
module hic_sync #(
    parameter int   W       = 1,
    parameter logic RST_LVL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic s1_q, s2_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q <= RST_LVL;
                s2_q <= RST_LVL;
            end else begin
                s1_q <= d_i[g];
                s2_q <= s1_q;
            end
        end
        assign q_o[g] = s2_q;
    end
endmodule

// File: rtl/hic_prio.sv
module hic_prio
    import hic_pkg::*;
#(
    parameter int N = N_REQ
) (
    input  logic [N-1:0]             req_i,
    output logic                     any_o,
    output logic [$clog2(N)-1:0]     idx_o
);
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                any_o = 1'b1;
                idx_o = ($clog2(N))'(i);
            end
        end
    end
endmodule

// File: rtl/halt_irq_ctrl.sv
module halt_irq_ctrl
    import hic_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EXT-1:0] irq_n_i,
    input  logic [N_EXT:0]   irq_en_i,
    input  logic             halt_instr_i,
    input  logic             halt_line_i,
    output logic             halt_line_o,
    output logic             halt_line_oe_o,
    input  logic             cont_i,
    output logic             cont_ack_o,
    input  logic             take_i,
    output logic             irq_valid_o,
    output logic [LVL_W-1:0] irq_level_o,
    output logic             halted_o
);
    hic_state_t q, d;

    logic [N_EXT-1:0] irq_s;
    logic             halt_s, cont_s;
    logic [N_REQ-1:0] req;
    logic             req_any;
    logic [IDX_W-1:0] req_idx;
    logic [LVL_W-1:0] req_code;
    logic             halt_fall, cont_rise;

    hic_sync #(.W(N_EXT), .RST_LVL(1'b1)) u_sync_irq (
        .clk(clk), .rst_n(rst_n), .d_i(irq_n_i), .q_o(irq_s));
    hic_sync #(.W(1), .RST_LVL(1'b1)) u_sync_halt (
        .clk(clk), .rst_n(rst_n), .d_i(halt_line_i), .q_o(halt_s));
    hic_sync #(.W(1), .RST_LVL(1'b0)) u_sync_cont (
        .clk(clk), .rst_n(rst_n), .d_i(cont_i), .q_o(cont_s));

    assign req = {(~irq_s) & irq_en_i[N_EXT:1], q.lvl0_pend};

    hic_prio #(.N(N_REQ)) u_prio (
        .req_i(req), .any_o(req_any), .idx_o(req_idx));

    assign req_code  = (req_idx == '0) ? '0 : LVL_W'(req_idx) + LVL_W'(1);
    assign halt_fall = q.halt_prev & ~halt_s;
    assign cont_rise = cont_s & ~q.cont_prev;

    always_comb begin
        d           = q;
        d.ack       = 1'b0;
        d.halt_prev = halt_s;
        d.cont_prev = cont_s;

        if (cont_rise && !halt_s && irq_en_i[0])
            d.lvl0_pend = 1'b1;

        if (halt_instr_i) begin
            d.halted = 1'b1;
            d.drive  = 1'b1;
        end else if (halt_fall) begin
            d.halted = 1'b1;
        end

        if (cont_rise) begin
            d.halted = 1'b0;
            d.drive  = 1'b0;
        end

        if (q.valid) begin
            if (take_i) begin
                d.valid  = 1'b0;
                d.ack    = 1'b1;
                d.halted = 1'b0;
                d.drive  = 1'b0;
                if (q.level == '0)
                    d.lvl0_pend = 1'b0;
            end
        end else if (req_any) begin
            d.valid = 1'b1;
            d.level = req_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q           <= '0;
            q.halt_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign irq_valid_o    = q.valid;
    assign irq_level_o    = q.level;
    assign cont_ack_o     = q.ack;
    assign halted_o       = q.halted;
    assign halt_line_o    = q.drive;
    assign halt_line_oe_o = q.drive;

    a_r6_ack_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        cont_ack_o |=> !cont_ack_o);
    a_r6_ack_drops_valid: assert property (@(posedge clk) disable iff (!rst_n)
        cont_ack_o |-> !irq_valid_o);
    a_r5_hold_until_take: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid_o && !take_i) |=> (irq_valid_o && $stable(irq_level_o)));
    a_r7_drive_only_halted: assert property (@(posedge clk) disable iff (!rst_n)
        halt_line_oe_o |-> halted_o);
    a_r11_ack_unhalts: assert property (@(posedge clk) disable iff (!rst_n)
        cont_ack_o |-> !halted_o);
    a_r2_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o |-> (irq_level_o != LVL_W'(1) && irq_level_o <= LVL_W'(N_EXT + 1)));
endmodule

// File: tb/halt_irq_ctrl_tb.sv
module halt_irq_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] irq_n = 4'hF;
    logic [4:0] irq_en = 5'h1F;
    logic       halt_instr = 1'b0;
    logic       halt_ext = 1'b1;
    logic       cont = 1'b0;
    logic       take = 1'b0;
    logic       halt_out, halt_oe, ack, valid, halted;
    logic [2:0] level;
    logic       halt_line;
    int         n_chk = 0;
    int         n_bad = 0;

    always #10 clk = ~clk;

    assign halt_line = halt_oe ? halt_out : halt_ext;

    halt_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .irq_n_i(irq_n), .irq_en_i(irq_en),
        .halt_instr_i(halt_instr), .halt_line_i(halt_line),
        .halt_line_o(halt_out), .halt_line_oe_o(halt_oe),
        .cont_i(cont), .cont_ack_o(ack), .take_i(take),
        .irq_valid_o(valid), .irq_level_o(level), .halted_o(halted));

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic take_it();
        take = 1'b1;
        step(1);
        take = 1'b0;
        chk(ack == 1'b1, "R6 ack high", ack, 1);
        chk(valid == 1'b0, "R6 valid dropped", valid, 0);
        step(1);
        chk(ack == 1'b0, "R6 ack one clock", ack, 0);
    endtask

    task automatic t_reset();
        chk(valid == 0 && ack == 0, "R1 valid/ack", {valid, ack}, 0);
        chk(halted == 0 && halt_oe == 0, "R1 halted/oe", {halted, halt_oe}, 0);
    endtask

    task automatic t_single();
        irq_n[1] = 1'b0;
        step(2);
        chk(valid == 0, "R2 not before third edge", valid, 0);
        step(1);
        chk(valid == 1 && level == 3, "R2 level of line 1", level, 3);
        irq_n[1] = 1'b1;
        step(3);
        chk(valid == 1 && level == 3, "R5 held after release", level, 3);
        take_it();
        chk(valid == 0, "R2 no reload after release", valid, 0);
    endtask

    task automatic t_priority();
        irq_n = 4'h0;
        step(3);
        chk(valid == 1 && level == 2, "R3 line 0 wins", level, 2);
        irq_n = 4'hF;
        step(3);
        take_it();
    endtask

    task automatic t_mask();
        irq_en = 5'b11011;
        irq_n[1] = 1'b0;
        step(5);
        chk(valid == 0, "R4 masked line ignored", valid, 0);
        irq_n[1] = 1'b1;
        step(3);
        irq_en = 5'h1F;
        step(1);
        chk(valid == 0, "R4 no late request", valid, 0);
    endtask

    task automatic t_hold();
        irq_n[3] = 1'b0;
        step(3);
        chk(valid == 1 && level == 5, "R2 lowest line", level, 5);
        irq_n[0] = 1'b0;
        step(3);
        chk(valid == 1 && level == 5, "R5 higher request waits", level, 5);
        irq_n = 4'hF;
        step(3);
        take_it();
    endtask

    task automatic t_instr_halt();
        halt_instr = 1'b1;
        step(1);
        halt_instr = 1'b0;
        chk(halted == 1, "R7 halted", halted, 1);
        chk(halt_oe == 1 && halt_out == 1, "R7 line driven high", {halt_oe, halt_out}, 3);
        cont = 1'b1;
        step(2);
        chk(halted == 1, "R9 not before third edge", halted, 1);
        step(1);
        chk(halted == 0 && halt_oe == 0, "R9 continue ends halt", {halted, halt_oe}, 0);
        step(2);
        chk(valid == 0, "R10 no level 0 with line high", valid, 0);
        cont = 1'b0;
        step(3);
    endtask

    task automatic t_level0();
        halt_ext = 1'b0;
        step(3);
        chk(halted == 1 && halt_oe == 0, "R8 external halt", {halted, halt_oe}, 2);
        cont = 1'b1;
        step(1);
        irq_n[3] = 1'b0;
        step(2);
        chk(halted == 0, "R9 halt ends", halted, 0);
        step(1);
        chk(valid == 1 && level == 0, "R10 R3 level 0 beats line 3", level, 0);
        halt_ext = 1'b1;
        cont = 1'b0;
        irq_n[3] = 1'b1;
        step(3);
        take_it();
        chk(valid == 0, "R10 level 0 cleared by ack", valid, 0);
        step(3);
    endtask

    task automatic t_ack_unhalt();
        halt_instr = 1'b1;
        step(1);
        halt_instr = 1'b0;
        irq_n[2] = 1'b0;
        step(3);
        chk(valid == 1 && level == 4, "R2 line 2", level, 4);
        irq_n[2] = 1'b1;
        step(3);
        chk(halted == 1, "R7 still halted", halted, 1);
        take = 1'b1;
        step(1);
        take = 1'b0;
        chk(ack == 1 && halted == 0 && halt_oe == 0, "R11 ack releases halt",
            {ack, halted, halt_oe}, 4);
        step(1);
    endtask

    task automatic t_masked_level0();
        irq_en = 5'b11110;
        halt_ext = 1'b0;
        step(3);
        chk(halted == 1, "R12 halted", halted, 1);
        cont = 1'b1;
        step(3);
        chk(halted == 0, "R12 halt still ends", halted, 0);
        step(2);
        chk(valid == 0, "R12 no level 0 request", valid, 0);
        halt_ext = 1'b1;
        cont = 1'b0;
        irq_en = 5'h1F;
        step(4);
        chk(valid == 0, "R12 nothing pending", valid, 0);
    endtask

    initial begin
        #100000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        step(1);
        t_reset();
        step(2);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_single();
        t_priority();
        t_mask();
        t_hold();
        t_instr_halt();
        t_level0();
        t_ack_unhalt();
        t_masked_level0();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule